// File: doc/BRIEF.md
# Serial DAC Command Register Core

This block is the digital front end of a 12-bit voltage DAC. A host writes it over a three-wire serial link: an active-low select, a serial clock and a data line. Each write is a 16-bit word. The top two bits are an operation code. The next twelve bits are a code or a sub-command. The last two bits carry nothing. The word goes into a shift register. When the select line is released, the word is decoded against a two-stage code store. The first stage is a staging (held) register. The second is the register that drives the converter (the DAC register).

The extended operation code controls two other things. The first is a general-purpose logic output. The second is the phase of the serial output, which is the tail of the shift register and is used for daisy-chaining. The block also sends a shutdown-request pulse and a wake pulse to a separate power controller. An active-low clear input forces the DAC register to zero or to mid-scale, and a select pin picks which one. The serial pins are sampled by the system clock, so the serial clock must run well below half the system clock rate.

Top module: `dac_cmd_core`

## Requirements
- R1: After synchronous reset, held_code and dac_code are 0, upo is 0, dout is 0, the output phase is the direct (non-delayed) one, and neither shdn_req nor wake is asserted.
- R2: A frame is bits sampled on rising serial-clock edges while cs_n is low, most significant bit first. Word bits [15:14] are the operation code, bits [13:2] are the 12-bit data and bits [1:0] are ignored. The select may stay low across a pause in the clock (for example two 8-bit bursts).
- R3: Operation code 00 writes the data into held_code and leaves dac_code unchanged.
- R4: Operation code 01 copies held_code into dac_code and produces a wake pulse.
- R5: Operation code 10 writes the data into both held_code and dac_code and produces a wake pulse.
- R6: Operation code 11 decodes data bits [11:9] (word bits [13:11]) and leaves both code registers unchanged. 000/001 do nothing. 010/011 produce a shutdown-request pulse. 100 drives upo low and 101 drives it high. 110 selects the half-clock-delayed serial output and 111 selects the direct one.
- R7: A frame executes on the rising edge of cs_n only if exactly 16 rising serial-clock edges were seen while cs_n was low. A frame of any other length changes nothing.
- R8: In the direct output phase, dout is the shift-register MSB. It changes after each rising serial-clock edge, so a bit reappears 16 edges after it entered.
- R9: In the delayed output phase, dout takes the shift-register MSB on each falling serial-clock edge while cs_n is low. This gives half a serial clock more lag than R8.
- R10: While clr_n is low, dac_code is set to 0 (rsel low) or 0x800 (rsel high), upo is set low, and held_code is kept. Clear overrides a frame that executes in the same cycle.
- R11: shdn_req and wake each last exactly one system-clock cycle per executed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| clr_n | input | 1 | Clear, active low, synchronous |
| rsel | input | 1 | Clear target: 0 gives zero, 1 gives mid-scale |
| dout | output | 1 | Serial data out (daisy chain) |
| held_code | output | 12 | Staging register contents |
| dac_code | output | 12 | Code driving the converter |
| upo | output | 1 | User logic output |
| shdn_req | output | 1 | One-cycle shutdown request |
| wake | output | 1 | One-cycle wake request |

## Verification
The bench sends 15-bit and 17-bit frames. A design that executed on any select release would load them. It sends a frame split into two bursts, and a counter that reset on a clock pause would drop that frame. The ignored trailing bits are set high, which catches a data field sliced one or two bits off. It samples dout in the middle of each clock-high phase of a following frame in both output phases. A design with the phases swapped or the delay missing would show the next bit early or late. A clear held across a loading frame checks that the clear wins and that held_code survives. Shutdown and wake pulses are counted and tested for width.

// File: rtl/dac_cmd_pkg.sv
// Shared types for the serial DAC command core.
// Assumes: the operation code sits in the two MSBs of the frame.
package dac_cmd_pkg;

    // Operation codes carried in word bits [15:14].
    typedef enum logic [1:0] {
        OP_STAGE    = 2'b00,
        OP_COMMIT   = 2'b01,
        OP_LOAD_ALL = 2'b10,
        OP_EXTENDED = 2'b11
    } op_e;

    // Upper two bits of the extended sub-command field.
    typedef enum logic [1:0] {
        XG_IDLE  = 2'b00,
        XG_SLEEP = 2'b01,
        XG_LOGIC = 2'b10,
        XG_PHASE = 2'b11
    } xgroup_e;

endpackage

// File: rtl/dac_serial_rx.sv
// Samples the three serial pins in the system clock domain. It finds the
// serial clock edges, shifts bits into a frame register and flags a complete
// frame when the select rises after exactly FRAME_BITS rising edges.
// Assumes: the serial clock is slower than clk/4 and pins are glitch free.
module dac_serial_rx #(
    parameter int FRAME_BITS = 16,
    parameter int TAIL_BITS  = 2,
    localparam int HEAD_W    = FRAME_BITS - TAIL_BITS,
    localparam int CNT_MAX   = FRAME_BITS + 1,
    localparam int CNT_W     = $clog2(FRAME_BITS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic [HEAD_W-1:0] frame_head,
    output logic              frame_valid,
    output logic              shift_msb,
    output logic              sclk_fall
);

    logic                  cs_q1, cs_q2;
    logic                  sck_q1, sck_q2;
    logic                  din_q1;
    logic                  sclk_rise;
    logic                  cs_release;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      edge_cnt;

    // Two-stage pin capture for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q1  <= 1'b1;
            cs_q2  <= 1'b1;
            sck_q1 <= 1'b0;
            sck_q2 <= 1'b0;
            din_q1 <= 1'b0;
        end else begin
            cs_q1  <= cs_n;
            cs_q2  <= cs_q1;
            sck_q1 <= sclk;
            sck_q2 <= sck_q1;
            din_q1 <= din;
        end
    end

    assign sclk_rise  = sck_q1 & ~sck_q2 & ~cs_q1;
    assign sclk_fall  = ~sck_q1 & sck_q2 & ~cs_q1;
    assign cs_release = cs_q1 & ~cs_q2;

    // Shift register, MSB first; not cleared between frames (daisy chain).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sclk_rise) begin
            shreg <= {shreg[FRAME_BITS-2:0], din_q1};
        end
    end

    // Rising edge counter, saturating one above a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_q1) begin
            edge_cnt <= '0;
        end else if (sclk_rise && edge_cnt != CNT_W'(CNT_MAX)) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    assign frame_valid = cs_release && (edge_cnt == CNT_W'(FRAME_BITS));
    assign frame_head  = shreg[FRAME_BITS-1:TAIL_BITS];
    assign shift_msb   = shreg[FRAME_BITS-1];

endmodule

// File: rtl/dac_dout_stage.sv
// Serial output driver. It passes the shift-register MSB straight through,
// or re-times it on the falling serial edge for half a clock more lag.
// Assumes: sclk_fall is a one-cycle strobe qualified by the select.
module dac_dout_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_msb,
    input  logic sclk_fall,
    input  logic half_delay,
    output logic dout
);

    logic late_bit;

    // Falling-edge copy of the shift-register MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late_bit <= 1'b0;
        end else if (sclk_fall) begin
            late_bit <= shift_msb;
        end
    end

    assign dout = half_delay ? late_bit : shift_msb;

endmodule

// File: rtl/dac_cmd_exec.sv
// Decodes a completed frame head and updates the two-stage code store, the
// logic output, the output phase and the power-controller pulses. The clear
// input has priority over a frame executing in the same cycle.
// Assumes: frame_valid is a single-cycle strobe.
module dac_cmd_exec
    import dac_cmd_pkg::*;
#(
    parameter int DATA_W  = 12,
    localparam int HEAD_W = DATA_W + 2,
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HEAD_W-1:0] frame_head,
    input  logic              frame_valid,
    input  logic              clr_n,
    input  logic              rsel,
    output logic [DATA_W-1:0] held_code,
    output logic [DATA_W-1:0] dac_code,
    output logic              upo,
    output logic              half_delay,
    output logic              shdn_req,
    output logic              wake
);

    op_e              op;
    logic [DATA_W-1:0] data;
    xgroup_e          xgrp;
    logic             xlsb;
    logic             do_stage, do_commit, do_all, do_ext;

    assign op   = op_e'(frame_head[HEAD_W-1 -: 2]);
    assign data = frame_head[DATA_W-1:0];
    assign xgrp = xgroup_e'(data[DATA_W-1 -: 2]);
    assign xlsb = data[DATA_W-3];

    // Qualified operation strobes.
    always_comb begin
        do_stage  = frame_valid && (op == OP_STAGE);
        do_commit = frame_valid && (op == OP_COMMIT);
        do_all    = frame_valid && (op == OP_LOAD_ALL);
        do_ext    = frame_valid && (op == OP_EXTENDED);
    end

    // Staging register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_code <= '0;
        end else if (do_stage || do_all) begin
            held_code <= data;
        end
    end

    // Converter register with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= '0;
        end else if (!clr_n) begin
            dac_code <= rsel ? MID_CODE : '0;
        end else if (do_commit) begin
            dac_code <= held_code;
        end else if (do_all) begin
            dac_code <= data;
        end
    end

    // User logic output; clear returns it to low.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            upo <= 1'b0;
        end else if (do_ext && xgrp == XG_LOGIC) begin
            upo <= xlsb;
        end
    end

    // Serial output phase select: sub-command 110 delays, 111 is direct.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_delay <= 1'b0;
        end else if (do_ext && xgrp == XG_PHASE) begin
            half_delay <= ~xlsb;
        end
    end

    // Single-cycle requests to the power controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shdn_req <= 1'b0;
            wake     <= 1'b0;
        end else begin
            shdn_req <= do_ext && (xgrp == XG_SLEEP);
            wake     <= do_commit || do_all;
        end
    end

endmodule

// File: rtl/dac_cmd_core.sv
// Top of the serial DAC command core: serial receiver, command executor and
// serial output driver. Frame length and code width follow DATA_W.
// Assumes: all inputs are synchronous to clk or slow enough to be sampled.
module dac_cmd_core #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              clr_n,
    input  logic              rsel,
    output logic              dout,
    output logic [DATA_W-1:0] held_code,
    output logic [DATA_W-1:0] dac_code,
    output logic              upo,
    output logic              shdn_req,
    output logic              wake
);

    localparam int TAIL_BITS  = 2;
    localparam int FRAME_BITS = DATA_W + 2 + TAIL_BITS;
    localparam int HEAD_W     = FRAME_BITS - TAIL_BITS;

    logic [HEAD_W-1:0] frame_head;
    logic              frame_valid;
    logic              shift_msb;
    logic              sclk_fall;
    logic              half_delay;

    dac_serial_rx #(
        .FRAME_BITS (FRAME_BITS),
        .TAIL_BITS  (TAIL_BITS)
    ) i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .din         (din),
        .frame_head  (frame_head),
        .frame_valid (frame_valid),
        .shift_msb   (shift_msb),
        .sclk_fall   (sclk_fall)
    );

    dac_cmd_exec #(
        .DATA_W (DATA_W)
    ) i_exec (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_head  (frame_head),
        .frame_valid (frame_valid),
        .clr_n       (clr_n),
        .rsel        (rsel),
        .held_code   (held_code),
        .dac_code    (dac_code),
        .upo         (upo),
        .half_delay  (half_delay),
        .shdn_req    (shdn_req),
        .wake        (wake)
    );

    dac_dout_stage i_dout (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_msb  (shift_msb),
        .sclk_fall  (sclk_fall),
        .half_delay (half_delay),
        .dout       (dout)
    );

endmodule

// File: rtl/dac_cmd_core_chk.sv
// Port-level properties of the command core, bound to every instance.
// Assumes: rst_n is low at time zero.
module dac_cmd_core_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              rsel,
    input logic [DATA_W-1:0] held_code,
    input logic [DATA_W-1:0] dac_code,
    input logic              upo,
    input logic              shdn_req,
    input logic              wake
);

    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    a_r10_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> dac_code == ($past(rsel) ? MID_CODE : '0));

    a_r10_clear_upo: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !upo);

    a_r11_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    a_r11_shdn_single: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req |=> !shdn_req);

    a_r6_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake && shdn_req));

    a_r4_wake_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && $past(clr_n)) |-> dac_code == held_code);

    a_r3_dac_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |-> (wake || !$past(clr_n)));

endmodule

bind dac_cmd_core dac_cmd_core_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .rsel      (rsel),
    .held_code (held_code),
    .dac_code  (dac_code),
    .upo       (upo),
    .shdn_req  (shdn_req),
    .wake      (wake)
);

// File: tb/test_dac_cmd_core.sv
// Scoreboard bench: driver tasks update a requirement model and queue the
// expected state; a monitor pops each item once the command has settled.
module test_dac_cmd_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        clr_n = 1'b1;
    logic        rsel = 1'b0;
    logic        dout;
    logic [11:0] held_code;
    logic [11:0] dac_code;
    logic        upo;
    logic        shdn_req;
    logic        wake;

    always #10 clk = ~clk;

    dac_cmd_core i_dac_cmd_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .clr_n     (clr_n),
        .rsel      (rsel),
        .dout      (dout),
        .held_code (held_code),
        .dac_code  (dac_code),
        .upo       (upo),
        .shdn_req  (shdn_req),
        .wake      (wake)
    );

    typedef struct {
        string       req;
        logic [11:0] held;
        logic [11:0] dac;
        logic        upo;
        int          wakes;
        int          shdns;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_errs = 0;
    bit          done = 1'b0;
    logic [11:0] m_held = '0;
    logic [11:0] m_dac = '0;
    logic        m_upo = 1'b0;
    bit          m_delay = 1'b0;
    int          m_wakes = 0;
    int          m_shdns = 0;
    int          wake_seen = 0;
    int          shdn_seen = 0;
    int          wide_pulses = 0;
    logic        wake_d = 1'b0;
    logic        shdn_d = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input logic [1:0] op, input logic [11:0] d,
                                       input logic [1:0] tail);
        return {op, d, tail};
    endfunction

    // MSB of the shift register after j rising edges of frame b following frame a.
    function automatic logic msb_after(input logic [15:0] a, input logic [15:0] b,
                                       input int j);
        if (j == 0)  return a[15];
        if (j < 16)  return a[15-j];
        return b[15];
    endfunction

    // Pulse counters (R11), sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wake) wake_seen++;
            if (shdn_req) shdn_seen++;
            if ((wake && wake_d) || (shdn_req && shdn_d)) wide_pulses++;
        end
        wake_d = wake;
        shdn_d = shdn_req;
    end

    // Serial driver: n bits MSB first; optional mid-frame pause and dout check.
    task automatic shift_bits(input logic [31:0] bits, input int n, input bit split,
                              input bit chk, input logic [15:0] prev);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            int k;
            k = n - i;
            din = bits[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(3);
            if (chk) begin
                if (m_delay)
                    check("R9", "delayed dout", dout, msb_after(prev, bits[15:0], k - 1));
                else
                    check("R8", "direct dout", dout, msb_after(prev, bits[15:0], k));
            end
            wait_clk(1);
            sclk = 1'b0;
            if (split && k == 8) wait_clk(20);
        end
        wait_clk(4);
        cs_n = 1'b1;
    endtask

    // Requirement model for one executed 16-bit word.
    task automatic model_apply(input logic [15:0] w);
        logic [11:0] d;
        d = w[13:2];
        case (w[15:14])
            2'b00: m_held = d;
            2'b01: begin m_dac = m_held; m_wakes++; end
            2'b10: begin m_held = d; m_dac = d; m_wakes++; end
            default: begin
                case (d[11:9])
                    3'b010, 3'b011: m_shdns++;
                    3'b100: m_upo = 1'b0;
                    3'b101: m_upo = 1'b1;
                    3'b110: m_delay = 1'b1;
                    3'b111: m_delay = 1'b0;
                    default: ;
                endcase
            end
        endcase
    endtask

    task automatic push_exp(input string req);
        exp_t e;
        e.req = req; e.held = m_held; e.dac = m_dac; e.upo = m_upo;
        e.wakes = m_wakes; e.shdns = m_shdns;
        sb_q.push_back(e);
    endtask

    task automatic frame(input logic [15:0] w, input string req, input bit split,
                         input bit clr_at_end, input bit clr_sel);
        shift_bits({16'h0, w}, 16, split, 1'b0, 16'h0);
        model_apply(w);
        if (clr_at_end) begin
            rsel = clr_sel;
            clr_n = 1'b0;
            m_dac = clr_sel ? 12'h800 : 12'h000;
            m_upo = 1'b0;
        end
        push_exp(req);
        if (clr_at_end) begin
            wait_clk(3);
            clr_n = 1'b1;
        end
        wait_clk(8);
    endtask

    task automatic clear(input bit sel);
        @(negedge clk);
        rsel = sel;
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        m_dac = sel ? 12'h800 : 12'h000;
        m_upo = 1'b0;
        push_exp("R10");
        wait_clk(8);
    endtask

    // Monitor: compare outputs once each queued command has settled.
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() > 0);
            e = sb_q.pop_front();
            wait_clk(4);
            check(e.req, "held_code", held_code, e.held);
            check(e.req, "dac_code", dac_code, e.dac);
            check(e.req, "upo", upo, e.upo);
            check(e.req, "wake count", wake_seen, e.wakes);
            check(e.req, "shdn count", shdn_seen, e.shdns);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        check("R1", "held_code", held_code, 12'h000);
        check("R1", "dac_code", dac_code, 12'h000);
        check("R1", "upo", upo, 1'b0);
        check("R1", "dout", dout, 1'b0);
        check("R1", "pulses", wake_seen + shdn_seen, 0);

        // R2/R3: staging load, ignored tail bits set high
        frame(mk(2'b00, 12'h5A3, 2'b11), "R3", 1'b0, 1'b0, 1'b0);
        frame(mk(2'b01, 12'h000, 2'b00), "R4", 1'b0, 1'b0, 1'b0);
        frame(mk(2'b00, 12'h123, 2'b10), "R3", 1'b0, 1'b0, 1'b0);
        frame(mk(2'b10, 12'hFED, 2'b01), "R5", 1'b0, 1'b0, 1'b0);
        // R2 split burst
        frame(mk(2'b10, 12'h321, 2'b00), "R2", 1'b1, 1'b0, 1'b0);

        // R7: short and long frames are discarded
        shift_bits({16'h0, mk(2'b10, 12'hAAA, 2'b00)}, 15, 1'b0, 1'b0, 16'h0);
        push_exp("R7");
        wait_clk(8);
        shift_bits({15'h0, 1'b0, mk(2'b10, 12'h555, 2'b00)}, 17, 1'b0, 1'b0, 16'h0);
        push_exp("R7");
        wait_clk(8);

        // R6 sub-commands
        frame(mk(2'b11, 12'hA00, 2'b00), "R6", 1'b0, 1'b0, 1'b0);
        frame(mk(2'b11, 12'h800, 2'b00), "R6", 1'b0, 1'b0, 1'b0);
        frame(mk(2'b11, 12'hBFF, 2'b11), "R6", 1'b0, 1'b0, 1'b0);
        frame(mk(2'b11, 12'h400, 2'b00), "R6", 1'b0, 1'b0, 1'b0);
        frame(mk(2'b11, 12'h600, 2'b00), "R6", 1'b0, 1'b0, 1'b0);
        frame(mk(2'b11, 12'h000, 2'b00), "R6", 1'b0, 1'b0, 1'b0);
        frame(mk(2'b11, 12'h3FF, 2'b00), "R6", 1'b0, 1'b0, 1'b0);

        // R10 clear to mid-scale and to zero
        clear(1'b1);
        frame(mk(2'b11, 12'hA00, 2'b00), "R6", 1'b0, 1'b0, 1'b0);
        clear(1'b0);
        // R10 clear overrides a load executing in the same cycle
        frame(mk(2'b10, 12'hABC, 2'b00), "R10", 1'b0, 1'b1, 1'b1);

        // R8 direct output phase
        frame(16'hC2A5, "R8", 1'b0, 1'b0, 1'b0);
        shift_bits({16'h0, 16'hC000}, 16, 1'b0, 1'b1, 16'hC2A5);
        push_exp("R8");
        wait_clk(8);

        // R9 delayed output phase
        frame(mk(2'b11, 12'hC00, 2'b00), "R9", 1'b0, 1'b0, 1'b0);
        frame(16'hC35A, "R9", 1'b0, 1'b0, 1'b0);
        shift_bits({16'h0, 16'hC1C3}, 16, 1'b0, 1'b1, 16'hC35A);
        push_exp("R9");
        wait_clk(8);

        // back to direct phase and recheck
        frame(mk(2'b11, 12'hE00, 2'b00), "R8", 1'b0, 1'b0, 1'b0);
        shift_bits({16'h0, 16'hC0F0}, 16, 1'b0, 1'b1, mk(2'b11, 12'hE00, 2'b00));
        push_exp("R8");
        wait_clk(12);

        check("R11", "wide pulses", wide_pulses, 0);
        wait (sb_q.size() == 0);
        wait_clk(8);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule